// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a watchdog counter on a small register bus (address, write strobe, write data, read data). Software configures it through one control word and observes it through a read-only status word. Writes to the control word go through a two-write key exchange. The first write carries an arming key. The second write carries a commit key together with the complete new configuration. The commit updates the enable, the warning level, the clock divider choice and the 16-bit reload value in one step, and it restarts the countdown from the new reload value.

When enabled, the counter decrements once per divided clock tick. A warning output rises when the count falls to a selectable fraction of the full 16-bit range. When the count reaches zero, the block issues a one-cycle reset request and records, in a flag that only power-on reset clears, that the watchdog caused the reset. Software keeps the system alive by repeating the key exchange with the reload value. It stops the timer by committing with the enable bit clear.

Top module: `wdog_guarded`

## Requirements
- R1: While and after power-on reset, the control readback and the status word are zero, and both the warning and the reset-request outputs are low.
- R2: The control word sits at byte offset 0x0. A write there whose bits 23:16 hold 0xBE only arms the exchange and changes nothing. The next control write with 0xDC in bits 23:16 commits bit 31 (enable), bits 27:26 (warning select), bits 25:24 (divider select) and bits 15:0 (reload). The control readback returns those fields in the same positions, with all other bits zero.
- R3: A control write with a key that is wrong for the current step changes nothing and drops the exchange back to idle. This includes 0xBE sent while already armed. A write to any other address between the two steps also drops the exchange.
- R4: A commit loads the counter with the reload value and restarts the divider. While enabled, the counter then drops by one every N clocks. N is the parameter chosen by divider code 0..3 (defaults 1, 64, 4096 and 0x40000). Repeating the commit with the reload value restarts the countdown.
- R5: The status word sits at byte offset 0x8 and is read-only. Bit 31 is the enable, bit 30 the watchdog-reset flag, bits 15:0 the live count, and all other bits read zero. Writes to it change nothing.
- R6: While enabled, the warning output is high exactly when the count is at or below 0xFFFF shifted right by (code+1). Code 0 gives 1/2 of the range, 1 gives 1/4, 2 gives 1/8 and 3 gives 1/16.
- R7: A divided tick that takes an enabled count from 1 to 0 produces a reset request lasting exactly one clock. The count then stays at zero, and a count committed as zero never requests a reset.
- R8: The watchdog-reset flag (status bit 30) sets together with the reset request. It survives later commits and clears only on power-on reset.
- R9: While disabled, the count holds its value, and neither the warning nor the reset request asserts.
- R10: When a commit and an expiring tick fall on the same clock edge, the commit wins. The counter reloads, and no reset request or flag results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address of the accessed register |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| prewarn_o | output | 1 | Count has reached the warning level |
| reset_req_o | output | 1 | One-cycle request to reset the system |

## Verification
Two events can land on the same clock edge: a keep-alive commit and the divided tick that would take the count from 1 to 0. The bench commits a reload of 3 at divide-by-one, sends the arming write, and waits one idle cycle. It then places the commit write on the exact edge where the count stands at 1. It then expects the count to read back as the new reload value, the reset request to stay low and the flag to stay clear. A later undisturbed run to zero shows that the same setup does expire when nothing interferes.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned CTRL_OFS = 0;
  localparam int unsigned STAT_OFS = 8;
  localparam logic [7:0]  KEY_ARM    = 8'hBE;
  localparam logic [7:0]  KEY_COMMIT = 8'hDC;

  typedef struct packed {
    logic             en;
    logic [1:0]       warn_sel;
    logic [1:0]       div_sel;
    logic [CNT_W-1:0] reload;
  } wdog_cfg_t;

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/wdog_unlock.sv
module wdog_unlock
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic       sel_ctrl,
  input  logic [7:0] key,
  output logic       commit
);
  typedef enum logic {ST_IDLE, ST_ARMED} ust_t;
  ust_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    commit  = 1'b0;
    if (wr) begin
      if (!sel_ctrl) begin
        state_d = ST_IDLE;
      end else if (state_q == ST_IDLE) begin
        state_d = (key == KEY_ARM) ? ST_ARMED : ST_IDLE;
      end else begin
        commit  = (key == KEY_COMMIT);
        state_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale
  import wdog_pkg::*;
#(
  parameter int unsigned DIV0 = 1,
  parameter int unsigned DIV1 = 64,
  parameter int unsigned DIV2 = 4096,
  parameter int unsigned DIV3 = 262144
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clr,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int unsigned DMAX = max4(DIV0, DIV1, DIV2, DIV3);
  localparam int unsigned PW   = (DMAX > 1) ? $clog2(DMAX) : 1;

  logic [PW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    case (sel)
      2'd0:    lim = PW'(DIV0 - 1);
      2'd1:    lim = PW'(DIV1 - 1);
      2'd2:    lim = PW'(DIV2 - 1);
      default: lim = PW'(DIV3 - 1);
    endcase
  end

  assign tick = run && !clr && (cnt_q == lim);

  always_comb begin
    if (clr || !run || tick) cnt_d = '0;
    else                     cnt_d = cnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  wdog_cfg_t        cfg_in,
  input  logic             tick,
  output wdog_cfg_t        cfg_q,
  output logic [CNT_W-1:0] count_q,
  output logic             req_q,
  output logic             cause_q,
  output logic             prewarn
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  wdog_cfg_t        cfg_d;
  logic [CNT_W-1:0] count_d, thr;
  logic             req_d, cause_d, step;

  assign step = cfg_q.en && tick && (count_q != '0);

  always_comb begin
    cfg_d   = commit ? cfg_in : cfg_q;
    count_d = count_q;
    if (commit)    count_d = cfg_in.reload;
    else if (step) count_d = count_q - CNT_W'(1);
    req_d   = !commit && step && (count_q == CNT_W'(1));
    cause_d = cause_q | req_d;
  end

  assign thr     = CMAX >> ({1'b0, cfg_q.warn_sel} + 3'd1);
  assign prewarn = cfg_q.en && (count_q <= thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      count_q <= '0;
      req_q   <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      count_q <= count_d;
      req_q   <= req_d;
      cause_q <= cause_d;
    end
  end
endmodule

// File: rtl/wdog_guarded.sv
module wdog_guarded
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DIV0   = 1,
  parameter int unsigned DIV1   = 64,
  parameter int unsigned DIV2   = 4096,
  parameter int unsigned DIV3   = 262144
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              prewarn_o,
  output logic              reset_req_o
);
  logic             rst_sync_n, sel_ctrl, sel_stat, commit, tick;
  logic             cause, prewarn, req;
  logic [CNT_W-1:0] count;
  wdog_cfg_t        cfg, cfg_in;

  assign sel_ctrl = (bus_addr == ADDR_W'(CTRL_OFS));
  assign sel_stat = (bus_addr == ADDR_W'(STAT_OFS));

  assign cfg_in.en       = bus_wdata[31];
  assign cfg_in.warn_sel = bus_wdata[27:26];
  assign cfg_in.div_sel  = bus_wdata[25:24];
  assign cfg_in.reload   = bus_wdata[CNT_W-1:0];

  wdog_rst_sync u_rsync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  wdog_unlock u_unlock (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr       (bus_wr),
    .sel_ctrl (sel_ctrl),
    .key      (bus_wdata[23:16]),
    .commit   (commit)
  );

  wdog_prescale #(
    .DIV0 (DIV0), .DIV1 (DIV1), .DIV2 (DIV2), .DIV3 (DIV3)
  ) u_presc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (cfg.en),
    .clr   (commit),
    .sel   (cfg.div_sel),
    .tick  (tick)
  );

  wdog_core u_core (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .commit  (commit),
    .cfg_in  (cfg_in),
    .tick    (tick),
    .cfg_q   (cfg),
    .count_q (count),
    .req_q   (req),
    .cause_q (cause),
    .prewarn (prewarn)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl) begin
      bus_rdata[31]      = cfg.en;
      bus_rdata[27:26]   = cfg.warn_sel;
      bus_rdata[25:24]   = cfg.div_sel;
      bus_rdata[15:0]    = cfg.reload;
    end else if (sel_stat) begin
      bus_rdata[31]      = cfg.en;
      bus_rdata[30]      = cause;
      bus_rdata[15:0]    = count;
    end
  end

  assign prewarn_o   = prewarn;
  assign reset_req_o = req;
endmodule

// File: rtl/wdog_guarded_chk.sv
module wdog_guarded_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        commit,
  input logic [15:0] reload_in,
  input logic [15:0] count,
  input logic        req,
  input logic        cause,
  input logic        prewarn
);
  // R4: a commit loads the counter from the written reload field
  a_r4_commit_loads: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (count == $past(reload_in)));

  // R7: the reset request lasts a single cycle
  a_r7_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);

  // R8: flag is raised whenever a request is out
  a_r8_req_sets_cause: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> cause);

  // R8: flag never clears while out of reset
  a_r8_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cause |=> cause);

  // R9: disabled counter holds unless a commit arrives
  a_r9_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !commit) |=> $stable(count));

  // R9: nothing asserts while disabled
  a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!prewarn && !req));

  // R10: a commit suppresses any request on its edge
  a_r10_commit_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !req);

  // R6: a zero count while enabled is always within warning range
  a_r6_warn_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en && count == 16'd0) |-> prewarn);
endmodule

bind wdog_guarded wdog_guarded_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .en        (cfg.en),
  .commit    (commit),
  .reload_in (bus_wdata[15:0]),
  .count     (count),
  .req       (reset_req_o),
  .cause     (cause),
  .prewarn   (prewarn_o)
);

// File: tb/wdog_guarded_test.sv
`timescale 1ns/1ps
module wdog_guarded_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        prewarn_o, reset_req_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdog_guarded #(.ADDR_W(4), .DIV0(1), .DIV1(2), .DIV2(4), .DIV3(8)) uut (
    .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wr (bus_wr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .prewarn_o (prewarn_o), .reset_req_o (reset_req_o)
  );

  // {config word, idle cycles, expected count, expected warning}
  localparam logic [64:0] VEC [9] = '{
    {32'h8C001004, 16'd4,  16'h1000, 1'b0},
    {32'h8C001004, 16'd5,  16'h0FFF, 1'b1},
    {32'h81008005, 16'd10, 16'h8000, 1'b0},
    {32'h81008005, 16'd12, 16'h7FFF, 1'b1},
    {32'h86004002, 16'd8,  16'h4000, 1'b0},
    {32'h86004002, 16'd12, 16'h3FFF, 1'b1},
    {32'h8B002001, 16'd7,  16'h2001, 1'b0},
    {32'h8B002001, 16'd16, 16'h1FFF, 1'b1},
    {32'h0C00000A, 16'd20, 16'h000A, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_bus(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic commit_cfg(input logic [31:0] w);
    wr_bus(4'h0, 32'h00BE0000);
    wr_bus(4'h0, w | 32'h00DC0000);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    idle(3);
    rd(4'h8, r); chk("R1 status in reset", r, 32'h0);
    rd(4'h0, r); chk("R1 ctrl in reset", r, 32'h0);
    chk("R1 outputs in reset", {30'd0, prewarn_o, reset_req_o}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    idle(3);
    rd(4'h8, r); chk("R1 status after reset", r, 32'h0);

    // table walk: R2 R4 R5 R6 R9
    for (int i = 0; i < 9; i++) begin
      logic [31:0] w;
      logic [15:0] wt, ec;
      logic        ep;
      {w, wt, ec, ep} = VEC[i];
      @(negedge clk);
      commit_cfg(w);
      idle(int'(wt));
      rd(4'h0, r); chk($sformatf("R2 ctrl readback v%0d", i), r, w);
      rd(4'h8, r); chk($sformatf("R4 R5 status v%0d", i), r, {w[31], 15'd0, ec});
      chk($sformatf("R6 R9 warning v%0d", i), {31'd0, prewarn_o}, {31'd0, ep});
    end

    // R3: commit key without arming
    wr_bus(4'h0, 32'h80DC0005);
    rd(4'h0, r); chk("R3 unarmed commit ignored", r, 32'h0C00000A);
    // R2: arming write alone changes nothing
    wr_bus(4'h0, 32'h8CBE0005);
    rd(4'h0, r); chk("R2 arm alone no change", r, 32'h0C00000A);
    // R3 R5: write to status aborts and is itself ignored
    wr_bus(4'h8, 32'hFFFFFFFF);
    wr_bus(4'h0, 32'h80DC0005);
    rd(4'h0, r); chk("R3 other address aborts", r, 32'h0C00000A);
    rd(4'h8, r); chk("R5 status write ignored", r, 32'h0000000A);
    // R3: double arm returns to idle
    wr_bus(4'h0, 32'h00BE0000);
    wr_bus(4'h0, 32'h00BE0000);
    wr_bus(4'h0, 32'h80DC0005);
    rd(4'h0, r); chk("R3 double arm aborts", r, 32'h0C00000A);
    // R3: wrong key aborts
    wr_bus(4'h0, 32'h00BE0000);
    wr_bus(4'h0, 32'h80000005);
    wr_bus(4'h0, 32'h80DC0005);
    rd(4'h0, r); chk("R3 wrong key aborts", r, 32'h0C00000A);

    // R10: commit on the expiring edge
    commit_cfg(32'h8C000003);
    wr_bus(4'h0, 32'h00BE0000);
    idle(1);
    rd(4'h8, r); chk("R10 count before clash", r, 32'h80000001);
    wr_bus(4'h0, 32'h8CDC0003);
    rd(4'h8, r); chk("R10 commit wins", r, 32'h80000003);
    chk("R10 no request", {31'd0, reset_req_o}, 32'h0);

    // R7 R8: undisturbed expiry
    idle(2);
    chk("R7 no request at one", {31'd0, reset_req_o}, 32'h0);
    idle(1);
    chk("R7 request on expiry", {31'd0, reset_req_o}, 32'h1);
    rd(4'h8, r); chk("R8 flag set on expiry", r, 32'hC0000000);
    idle(1);
    chk("R7 request one cycle", {31'd0, reset_req_o}, 32'h0);
    idle(3);
    rd(4'h8, r); chk("R7 count stays zero", r, 32'hC0000000);

    // R4 R8: keep-alive reload, flag survives
    commit_cfg(32'h8C000064);
    rd(4'h8, r); chk("R4 R8 keepalive reload", r, 32'hC0000064);

    // R9: stop
    commit_cfg(32'h0C000064);
    idle(5);
    rd(4'h8, r); chk("R9 stopped holds", r, 32'h40000064);
    chk("R9 stopped quiet", {30'd0, prewarn_o, reset_req_o}, 32'h0);

    // R8: only power-on reset clears the flag
    rst_n = 1'b0;
    idle(2);
    rd(4'h8, r); chk("R8 flag cleared by reset", r, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    idle(3);

    // R7: zero reload never requests
    commit_cfg(32'h8C000000);
    for (int k = 0; k < 5; k++) begin
      chk("R7 zero reload no request", {31'd0, reset_req_o}, 32'h0);
      idle(1);
    end
    rd(4'h8, r); chk("R7 R8 zero reload status", r, 32'h80000000);

    finish_run();
  end
endmodule